// File: doc/BRIEF.md
# Multi-Unit Execution Stage with Condition Select

This block is the arithmetic core of a 32-bit datapath. It is purely combinational. It receives two operand words, D1 and D2, and offers four function units: an adder/subtractor, a bitwise logic unit, a funnel shifter and a leading-one priority encoder. A unit-select code chooses which unit drives the result word, and a result-valid strobe says whether that word is meaningful.

The adder is evaluated for every operation, whichever unit is selected. Its overflow, carry and signed greater-than flags are therefore always available. A condition-select code picks one of these three flags, or a constant true, onto a single condition output. Subtraction inverts D1, not D2, so the subtract forms compute D2 - D1.

Codes that name no unit, and logic-op codes with no function, raise an illegal-operation flag and return a zero result. Register files, operand steering and flag storage belong to the surrounding pipeline.

Top module: `exs_stage`

## Requirements
- R1: `add_op` selects the adder function: 0 gives D1+D2, 1 gives D1+D2+1, 2 gives (NOT D1)+D2, and 3 gives (NOT D1)+D2+1. The result is the low 32 bits.
- R2: The carry flag is the carry out of bit 31 of the adder sum, carry-in included.
- R3: The overflow flag is 1 exactly when the two adder inputs (the possibly inverted D1, and D2) have equal sign bits and the sum's sign bit differs from them.
- R4: The greater-than flag equals the carry flag when the adder input sign bits differ. Otherwise it equals bit 31 of the original D1.
- R5: With `unit_sel`=2, `logic_op` selects the logic function: 0 is AND, 1 is XOR, 2 is OR, 3 is NOR, and 4 is NAND.
- R6: With `unit_sel`=3, the result is the low 32 bits of the 64-bit word {D2,D1} shifted right by the 6-bit `shamt` (0 to 63).
- R7: With `unit_sel`=4, the result is the index (0 to 31, bit 0 is the LSB) of the highest set bit of D1. It is 32 when D1 is zero.
- R8: `cond_sel` drives `cond_out`: 0 gives overflow, 1 gives carry, 2 gives greater-than, and 3 gives constant 1.
- R9: With `unit_sel`=0 (NOP), `result_valid` is 0, `illegal_op` is 0 and `result` carries the adder sum. The flags on `cond_out` are still produced.
- R10: With `unit_sel`=1, the adder sum is the result. With any legal, non-NOP selection, `result_valid` is 1.
- R11: A `unit_sel` of 5, 6 or 7, or `unit_sel`=2 with a `logic_op` of 5, 6 or 7, sets `illegal_op`=1. In that case `result` is 0 and `result_valid` is 0.
- R12: The adder flags on `cond_out` do not depend on `unit_sel`. They are identical under every unit selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d1 | input | 32 | First operand |
| d2 | input | 32 | Second operand |
| unit_sel | input | 3 | Unit select: 0 NOP, 1 adder, 2 logic, 3 shifter, 4 priority |
| add_op | input | 2 | Adder function code |
| logic_op | input | 3 | Logic function code |
| shamt | input | 6 | Shifter right-shift amount |
| cond_sel | input | 2 | Condition-output select |
| result | output | 32 | Selected unit's result |
| result_valid | output | 1 | Result is from a legal, non-NOP unit |
| cond_out | output | 1 | Selected adder flag, or constant 1 |
| illegal_op | output | 1 | Unsupported unit or logic code |

## Verification
The bench builds the block with its default 32-bit width, so the shift amount spans its full 0 to 63 range. That width reaches the cases where the whole result comes from D2, or from D2's top bit only. It also reaches the sign boundaries at bit 31, where the overflow and greater-than rules switch behaviour, and the 32 returned for a zero word. Adder vectors include the most negative and most positive words and all-ones words, so that carry and overflow are seen apart and together.

// File: rtl/exs_pkg.sv
// Package: shared codes for the execution stage.
// Assumes operand width is set at the top; codes here are width-free.
package exs_pkg;

    typedef enum logic [2:0] {
        UNIT_NOP   = 3'd0,
        UNIT_ADD   = 3'd1,
        UNIT_LOGIC = 3'd2,
        UNIT_SHIFT = 3'd3,
        UNIT_PRIO  = 3'd4
    } unit_e;

    typedef enum logic [1:0] {
        AOP_ADD  = 2'd0,
        AOP_ADDC = 2'd1,
        AOP_SUB  = 2'd2,
        AOP_SUBC = 2'd3
    } add_op_e;

    typedef enum logic [2:0] {
        LOP_AND  = 3'd0,
        LOP_XOR  = 3'd1,
        LOP_OR   = 3'd2,
        LOP_NOR  = 3'd3,
        LOP_NAND = 3'd4
    } logic_op_e;

    typedef enum logic [1:0] {
        CSEL_OVF   = 2'd0,
        CSEL_CARRY = 2'd1,
        CSEL_GT    = 2'd2,
        CSEL_TRUE  = 2'd3
    } cond_sel_e;

endpackage

// File: rtl/exs_adder.sv
// Adder/subtractor with flags.
// op[1] inverts the first operand; op[0] supplies a carry-in of one.
// Assumes W >= 2. Purely combinational.
module exs_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf,
    output logic         gt
);
    logic [W-1:0] in1;
    logic [W:0]   wide;

    // Condition first operand and form the extended sum.
    always_comb begin
        in1  = op[1] ? ~a : a;
        wide = {1'b0, in1} + {1'b0, b} + {{W{1'b0}}, op[0]};
    end

    assign sum   = wide[W-1:0];
    assign carry = wide[W];

    // Derive overflow and greater-than from sign bits.
    always_comb begin
        ovf = (in1[W-1] == b[W-1]) && (sum[W-1] != in1[W-1]);
        gt  = (in1[W-1] != b[W-1]) ? carry : a[W-1];
    end

    // Guard: overflow only with matching input signs.
    always_comb begin
        // R3
        if (ovf) begin
            ovf_sign_chk: assert (in1[W-1] == b[W-1] && sum[W-1] != b[W-1]);
        end
    end
endmodule

// File: rtl/exs_logic.sv
// Bitwise logic unit. Codes above the last function raise bad_op and give zero.
// Assumes the op codes of exs_pkg.
module exs_logic
    import exs_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] y,
    output logic         bad_op
);
    // Pick the bitwise function.
    always_comb begin
        bad_op = 1'b0;
        case (op)
            LOP_AND:  y = a & b;
            LOP_XOR:  y = a ^ b;
            LOP_OR:   y = a | b;
            LOP_NOR:  y = ~(a | b);
            LOP_NAND: y = ~(a & b);
            default: begin
                y      = '0;
                bad_op = 1'b1;
            end
        endcase
    end

    // Guard: an unknown code never leaks data.
    always_comb begin
        // R11
        if (bad_op) begin
            logic_bad_zero_chk: assert (y == '0);
        end
    end
endmodule

// File: rtl/exs_shifter.sv
// Funnel shifter: {hi,lo} shifted right, low W bits kept.
// Assumes SW is wide enough to reach 2*W-1.
module exs_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(2 * W)
) (
    input  logic [W-1:0]  lo,
    input  logic [W-1:0]  hi,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  y
);
    assign y = W'({hi, lo} >> amt);

    // Guard: zero shift passes the low word through.
    always_comb begin
        // R6
        if (amt == '0) begin
            shift_zero_chk: assert (y == lo);
        end
    end
endmodule

// File: rtl/exs_prio.sv
// Leading-one priority encoder: index of highest set bit, or W for zero.
// Assumes PW bits can hold the value W.
module exs_prio #(
    parameter int W  = 32,
    parameter int PW = $clog2(W) + 1
) (
    input  logic [W-1:0]  x,
    output logic [PW-1:0] idx
);
    // Scan upward; the highest set bit writes last.
    always_comb begin
        idx = PW'(W);
        for (int i = 0; i < W; i++) begin
            if (x[i]) idx = PW'(i);
        end
    end

    // Guard: index range and zero code.
    always_comb begin
        // R7
        prio_range_chk: assert (idx <= PW'(W));
        // R7
        if (x == '0) begin
            prio_zero_chk: assert (idx == PW'(W));
        end else begin
            prio_hit_chk: assert (x[idx[PW-2:0]] == 1'b1);
        end
    end
endmodule

// File: rtl/exs_stage.sv
// Execution stage top: four units, result select and condition select.
// The adder always runs so its flags are valid for every unit code.
// Assumes operands are stable for the evaluation; no state is held.
module exs_stage
    import exs_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(2 * W)
) (
    input  logic [W-1:0]  d1,
    input  logic [W-1:0]  d2,
    input  logic [2:0]    unit_sel,
    input  logic [1:0]    add_op,
    input  logic [2:0]    logic_op,
    input  logic [SW-1:0] shamt,
    input  logic [1:0]    cond_sel,
    output logic [W-1:0]  result,
    output logic          result_valid,
    output logic          cond_out,
    output logic          illegal_op
);
    localparam int PW = $clog2(W) + 1;

    logic [W-1:0]  add_sum;
    logic          f_carry;
    logic          f_ovf;
    logic          f_gt;
    logic [W-1:0]  lu_y;
    logic          lu_bad;
    logic [W-1:0]  sh_y;
    logic [PW-1:0] pr_idx;

    exs_adder #(.W(W)) u_adder (
        .a(d1), .b(d2), .op(add_op),
        .sum(add_sum), .carry(f_carry), .ovf(f_ovf), .gt(f_gt)
    );

    exs_logic #(.W(W)) u_logic (
        .a(d1), .b(d2), .op(logic_op), .y(lu_y), .bad_op(lu_bad)
    );

    exs_shifter #(.W(W), .SW(SW)) u_shift (
        .lo(d1), .hi(d2), .amt(shamt), .y(sh_y)
    );

    exs_prio #(.W(W), .PW(PW)) u_prio (
        .x(d1), .idx(pr_idx)
    );

    // Route the selected unit to the result and flag bad codes.
    always_comb begin
        result       = '0;
        result_valid = 1'b1;
        illegal_op   = 1'b0;
        case (unit_sel)
            UNIT_NOP: begin
                result       = add_sum;
                result_valid = 1'b0;
            end
            UNIT_ADD:   result = add_sum;
            UNIT_LOGIC: begin
                result       = lu_y;
                illegal_op   = lu_bad;
                result_valid = ~lu_bad;
            end
            UNIT_SHIFT: result = sh_y;
            UNIT_PRIO:  result = {{(W - PW){1'b0}}, pr_idx};
            default: begin
                result_valid = 1'b0;
                illegal_op   = 1'b1;
            end
        endcase
    end

    // Choose the flag presented on the condition output.
    always_comb begin
        case (cond_sel)
            CSEL_OVF:   cond_out = f_ovf;
            CSEL_CARRY: cond_out = f_carry;
            CSEL_GT:    cond_out = f_gt;
            default:    cond_out = 1'b1;
        endcase
    end

    // Guard: output-level rules across units.
    always_comb begin
        // R11
        if (illegal_op) begin
            illegal_zero_chk: assert (result == '0 && !result_valid);
        end
        // R9
        if (unit_sel == UNIT_NOP) begin
            nop_invalid_chk: assert (!result_valid && !illegal_op);
        end
        // R8
        if (cond_sel == CSEL_TRUE) begin
            cond_true_chk: assert (cond_out);
        end
        // R10
        if (result_valid) begin
            valid_legal_chk: assert (!illegal_op && unit_sel != UNIT_NOP);
        end
    end
endmodule

// File: tb/exs_stage_tb_top.sv
// Directed bench for exs_stage; each task applies and checks one scenario.
module exs_stage_tb_top;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] d1, d2, result;
    logic [2:0]   unit_sel, logic_op;
    logic [1:0]   add_op, cond_sel;
    logic [5:0]   shamt;
    logic         result_valid, cond_out, illegal_op;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    exs_stage dut_i (
        .d1(d1), .d2(d2), .unit_sel(unit_sel), .add_op(add_op),
        .logic_op(logic_op), .shamt(shamt), .cond_sel(cond_sel),
        .result(result), .result_valid(result_valid),
        .cond_out(cond_out), .illegal_op(illegal_op)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference adder computed from the written rules.
    task automatic ref_add(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                           output logic [W-1:0] s, output logic c, output logic v, output logic g);
        logic [W-1:0] x;
        logic [W:0]   t;
        x = op[1] ? ~a : a;
        t = {1'b0, x} + {1'b0, b} + (op[0] ? 33'd1 : 33'd0);
        s = t[W-1:0];
        c = t[W];
        v = (x[W-1] == b[W-1]) && (s[W-1] != x[W-1]);
        g = (x[W-1] != b[W-1]) ? c : a[W-1];
    endtask

    task automatic apply(input logic [2:0] u, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [1:0] aop, input logic [2:0] lop, input logic [5:0] sa,
                         input logic [1:0] cs);
        @(posedge clk);
        unit_sel = u; d1 = a; d2 = b; add_op = aop; logic_op = lop; shamt = sa; cond_sel = cs;
        @(negedge clk);
    endtask

    // Check sum and all three flags for one adder vector.
    task automatic t_add_vec(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] s;
        logic c, v, g;
        ref_add(op, a, b, s, c, v, g);
        apply(3'd1, a, b, op, 3'd0, 6'd0, 2'd0);
        chk("R1 sum", result, s);
        chk("R10 valid", {31'd0, result_valid}, 32'd1);
        chk("R3 ovf", {31'd0, cond_out}, {31'd0, v});
        apply(3'd1, a, b, op, 3'd0, 6'd0, 2'd1);
        chk("R2 carry", {31'd0, cond_out}, {31'd0, c});
        apply(3'd1, a, b, op, 3'd0, 6'd0, 2'd2);
        chk("R4 gt", {31'd0, cond_out}, {31'd0, g});
    endtask

    task automatic t_reset_state;
        apply(3'd0, '0, '0, 2'd0, 3'd0, 6'd0, 2'd3);
        chk("R9 idle valid", {31'd0, result_valid}, 32'd0);
        chk("R9 idle illegal", {31'd0, illegal_op}, 32'd0);
        chk("R8 idle cond", {31'd0, cond_out}, 32'd1);
    endtask

    task automatic t_adder;
        t_add_vec(2'd0, 32'h0000_0005, 32'h0000_0007);
        t_add_vec(2'd1, 32'hFFFF_FFFF, 32'h0000_0000);
        t_add_vec(2'd0, 32'h7FFF_FFFF, 32'h0000_0001);
        t_add_vec(2'd0, 32'h8000_0000, 32'h8000_0000);
        t_add_vec(2'd2, 32'h0000_0003, 32'h0000_000A);
        t_add_vec(2'd3, 32'h0000_0003, 32'h0000_000A);
        t_add_vec(2'd3, 32'h0000_000A, 32'h0000_0003);
        t_add_vec(2'd3, 32'h7FFF_FFFF, 32'h8000_0000);
        t_add_vec(2'd2, 32'h8000_0000, 32'h7FFF_FFFF);
        t_add_vec(2'd1, 32'h1234_5678, 32'hEDCB_A987);
    endtask

    task automatic t_logic;
        logic [W-1:0] a = 32'hF0F0_3C3C;
        logic [W-1:0] b = 32'hFF00_5A5A;
        apply(3'd2, a, b, 2'd0, 3'd0, 6'd0, 2'd3);
        chk("R5 and", result, a & b);
        apply(3'd2, a, b, 2'd0, 3'd1, 6'd0, 2'd3);
        chk("R5 xor", result, a ^ b);
        apply(3'd2, a, b, 2'd0, 3'd2, 6'd0, 2'd3);
        chk("R5 or", result, a | b);
        apply(3'd2, a, b, 2'd0, 3'd3, 6'd0, 2'd3);
        chk("R5 nor", result, ~(a | b));
        apply(3'd2, a, b, 2'd0, 3'd4, 6'd0, 2'd3);
        chk("R5 nand", result, ~(a & b));
        chk("R10 logic valid", {31'd0, result_valid}, 32'd1);
    endtask

    task automatic t_shift;
        logic [W-1:0] a = 32'h8765_4321;
        logic [W-1:0] b = 32'hC0DE_F00D;
        logic [63:0] cat = {b, a};
        for (int s = 0; s < 64; s += 7) begin
            apply(3'd3, a, b, 2'd0, 3'd0, 6'(s), 2'd3);
            chk("R6 shift", result, cat[s +: 32] & ((s <= 32) ? 32'hFFFF_FFFF : (32'hFFFF_FFFF >> (s - 32))));
        end
        apply(3'd3, a, b, 2'd0, 3'd0, 6'd32, 2'd3);
        chk("R6 shift32", result, b);
        apply(3'd3, a, b, 2'd0, 3'd0, 6'd63, 2'd3);
        chk("R6 shift63", result, 32'd1);
        apply(3'd3, a, b, 2'd0, 3'd0, 6'd0, 2'd3);
        chk("R6 shift0", result, a);
    endtask

    task automatic t_prio;
        apply(3'd4, 32'd0, 32'hFFFF_FFFF, 2'd0, 3'd0, 6'd0, 2'd3);
        chk("R7 zero", result, 32'd32);
        apply(3'd4, 32'd1, 32'd0, 2'd0, 3'd0, 6'd0, 2'd3);
        chk("R7 lsb", result, 32'd0);
        apply(3'd4, 32'h8000_0001, 32'd0, 2'd0, 3'd0, 6'd0, 2'd3);
        chk("R7 msb", result, 32'd31);
        apply(3'd4, 32'h0001_FFFF, 32'd0, 2'd0, 3'd0, 6'd0, 2'd3);
        chk("R7 mid", result, 32'd16);
    endtask

    task automatic t_nop_flags;
        logic [W-1:0] s;
        logic c, v, g;
        ref_add(2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, s, c, v, g);
        apply(3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd0, 3'd0, 6'd0, 2'd0);
        chk("R9 nop valid", {31'd0, result_valid}, 32'd0);
        chk("R9 nop sum", result, s);
        chk("R9 nop ovf", {31'd0, cond_out}, {31'd0, v});
    endtask

    task automatic t_flag_units;
        logic [W-1:0] s;
        logic c, v, g;
        ref_add(2'd1, 32'hFFFF_FFFF, 32'h0000_0001, s, c, v, g);
        for (int u = 0; u < 8; u++) begin
            apply(3'(u), 32'hFFFF_FFFF, 32'h0000_0001, 2'd1, 3'd0, 6'd4, 2'd1);
            chk("R12 carry per unit", {31'd0, cond_out}, {31'd0, c});
        end
    endtask

    task automatic t_illegal;
        for (int u = 5; u < 8; u++) begin
            apply(3'(u), 32'hDEAD_BEEF, 32'h1234_5678, 2'd0, 3'd0, 6'd0, 2'd3);
            chk("R11 unit flag", {31'd0, illegal_op}, 32'd1);
            chk("R11 unit result", result, 32'd0);
            chk("R11 unit valid", {31'd0, result_valid}, 32'd0);
        end
        for (int o = 5; o < 8; o++) begin
            apply(3'd2, 32'hDEAD_BEEF, 32'h1234_5678, 2'd0, 3'(o), 6'd0, 2'd3);
            chk("R11 lop flag", {31'd0, illegal_op}, 32'd1);
            chk("R11 lop result", result, 32'd0);
        end
        apply(3'd3, 32'hDEAD_BEEF, 32'h1234_5678, 2'd0, 3'd7, 6'd0, 2'd3);
        chk("R11 lop ignored off logic", {31'd0, illegal_op}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        unit_sel = '0; d1 = '0; d2 = '0; add_op = '0; logic_op = '0; shamt = '0; cond_sel = 2'd3;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_adder();
        t_logic();
        t_shift();
        t_prio();
        t_nop_flags();
        t_flag_units();
        t_illegal();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule